// File: doc/BRIEF.md
# Multiplexed Grid Scan and Dimming Timer

This block is the master time base for a vacuum-fluorescent display that shares one set of segment lines between two or three grids. It divides an oscillator clock enable into bit times, runs a fixed-length slot for each grid in turn, and drives the active-low grid lines. The grid is lit for the number of bit times given by a 10-bit brightness value. Inside that lit window it raises a segment-enable pulse that is held back by a short blanking gap at both ends. This keeps segment data from bleeding into the neighbouring grid.

For a second, slave driver, the block also outputs a dimming pulse, which is the lit window itself, and a 2-bit sync code that names the current grid. The brightness value is captured only at the start of a slot, so a write that lands mid-slot never cuts a pulse short. The duplex select picks a two-grid or a three-grid scan.

Top module: `vfd_scan_timer`

## Requirements
- R1: While rst_ni is low, and after it is released until the first enabled bit time ends, all three grid_no_o lines are 1, seg_en_o and dim_out_o are 0, and grid_idx_o and sync_o are 2'b00.
- R2: Time advances only on clocks where osc_en_i is 1. One bit time is OSC_DIV (default 4) such clocks. With osc_en_i held low, every output holds its value.
- R3: A slot lasts SLOT_BITS (default 1024) bit times. grid_idx_o steps through 0,1 when duplex_i is 1 and through 0,1,2 when duplex_i is 0, and then wraps to 0. It changes only at a slot start.
- R4: grid_no_o[k] is 0 exactly when grid_idx_o equals k and the bit position b within the slot (0 to SLOT_BITS-1) is less than the effective duty D. No more than one grid line is low at any time.
- R5: The effective duty D is the brightness value saturated at DIM_CAP (default 1016). Any dim_i above 1016 behaves as 1016, and 0 gives a dark slot.
- R6: seg_en_o is 1 exactly when b >= SEG_LEAD (3) and b + SEG_TRAIL (5) < D. It is only ever high while a grid line is low.
- R7: dim_out_o is 1 exactly when some grid line is low, which is the window b < D.
- R8: sync_o carries the grid code: 2'b00 for the first grid, 2'b01 for the second, 2'b10 for the third. It equals grid_idx_o at all times.
- R9: D is loaded from dim_i only at the clock edge that starts a new slot. A change of dim_i in mid-slot first shows in the next slot. D is 0 from reset until the first slot boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_en_i | input | 1 | Oscillator clock enable, one per oscillator period |
| duplex_i | input | 1 | 1 selects a 2-grid scan, 0 selects a 3-grid scan |
| dim_i | input | 10 | Brightness value, in bit times of grid-on per slot |
| grid_no_o | output | 3 | Grid enables, active low, bit k for grid k |
| grid_idx_o | output | 2 | Index of the grid that owns the current slot |
| seg_en_o | output | 1 | Segment enable pulse, blanked inside the grid window |
| dim_out_o | output | 1 | Dimming pulse for a slave driver |
| sync_o | output | 2 | Grid code for a slave driver |

## Verification
The embedded assertions check the following on every cycle:
- The counters freeze while osc_en_i is low.
- The duty never exceeds its cap, and it moves only at a slot boundary.
- At most one grid line is low.
- The segment pulse never appears outside a lit grid.
- The dimming pulse and the grid lines agree.
- The grid index stays in range for the selected scan.

Only the bench's scenarios show whether the pulse edges fall on the exact bit positions, whether the scan order and its wrap are correct in both modes, and whether the saturated and mid-slot brightness values land in the right slot. For that, the bench tracks elapsed enabled clocks, under random gaps in the oscillator enable.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;

  typedef enum logic [1:0] {
    GRID_FIRST  = 2'b00,
    GRID_SECOND = 2'b01,
    GRID_THIRD  = 2'b10
  } grid_code_e;

  localparam int unsigned GRID_CNT_MAX = 3;

  function automatic grid_code_e next_grid(grid_code_e cur, logic duplex);
    grid_code_e last;
    last = duplex ? GRID_SECOND : GRID_THIRD;
    if (cur == last || cur > last) return GRID_FIRST;
    return grid_code_e'(cur + 2'd1);
  endfunction

endpackage

// File: rtl/vfd_prescale.sv
module vfd_prescale #(
  parameter int unsigned OSC_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_en_i,
  output logic bit_tick_o
);
  localparam int unsigned CW = (OSC_DIV > 2) ? $clog2(OSC_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(OSC_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign bit_tick_o = osc_en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (bit_tick_o) cnt_q <= '0;
    else if (osc_en_i)  cnt_q <= cnt_q + 1'b1;
  end

  // R2
  prescale_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_i |=> $stable(cnt_q));

endmodule

// File: rtl/vfd_slot_seq.sv
module vfd_slot_seq
  import vfd_scan_pkg::*;
#(
  parameter int unsigned SLOT_BITS = 1024,
  parameter int unsigned DIM_W     = 10,
  parameter int unsigned DIM_CAP   = 1016
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         bit_tick_i,
  input  logic                         duplex_i,
  input  logic [DIM_W-1:0]             dim_i,
  output logic [$clog2(SLOT_BITS)-1:0] bit_pos_o,
  output grid_code_e                   grid_o,
  output logic [DIM_W-1:0]             duty_o
);
  localparam int unsigned BW = $clog2(SLOT_BITS);
  localparam logic [BW-1:0]    LAST_BIT = BW'(SLOT_BITS - 1);
  localparam logic [DIM_W-1:0] CAP      = DIM_W'(DIM_CAP);

  logic [BW-1:0]    bit_q;
  grid_code_e       grid_q;
  logic [DIM_W-1:0] duty_q;
  logic             slot_end;
  logic [DIM_W-1:0] dim_sat;

  assign slot_end = bit_tick_i && (bit_q == LAST_BIT);
  assign dim_sat  = (dim_i > CAP) ? CAP : dim_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= '0;
      grid_q <= GRID_FIRST;
      duty_q <= '0;
    end else if (slot_end) begin
      bit_q  <= '0;
      grid_q <= next_grid(grid_q, duplex_i);
      duty_q <= dim_sat;
    end else if (bit_tick_i) begin
      bit_q  <= bit_q + 1'b1;
    end
  end

  assign bit_pos_o = bit_q;
  assign grid_o    = grid_q;
  assign duty_o    = duty_q;

  // R5
  duty_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    duty_q <= CAP);

  // R9
  duty_slot_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(duty_q) |-> $past(slot_end));

  // R3
  grid_slot_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(grid_q) |-> (bit_q == '0));

  // R3
  grid_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grid_q != 2'b11);

  // R2
  bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_tick_i |=> $stable(bit_q));

endmodule

// File: rtl/vfd_pulse_gen.sv
module vfd_pulse_gen
  import vfd_scan_pkg::*;
#(
  parameter int unsigned BW        = 10,
  parameter int unsigned DIM_W     = 10,
  parameter int unsigned SEG_LEAD  = 3,
  parameter int unsigned SEG_TRAIL = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BW-1:0]    bit_pos_i,
  input  grid_code_e       grid_i,
  input  logic [DIM_W-1:0] duty_i,
  output logic [GRID_CNT_MAX-1:0] grid_no_o,
  output logic             seg_en_o,
  output logic             dim_out_o
);
  int unsigned pos;
  int unsigned duty;
  logic        lit;

  always_comb begin
    pos  = 32'(bit_pos_i);
    duty = 32'(duty_i);
    lit  = pos < duty;
  end

  for (genvar k = 0; k < GRID_CNT_MAX; k++) begin : g_grid
    assign grid_no_o[k] = !(lit && (grid_i == grid_code_e'(k)));
  end

  assign seg_en_o  = (pos >= SEG_LEAD) && (pos + SEG_TRAIL < duty);
  assign dim_out_o = lit;

  // R4
  one_grid_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~grid_no_o) <= 1);

  // R6
  seg_in_grid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_en_o |-> (grid_no_o != '1));

  // R7
  dim_matches_grid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dim_out_o == (grid_no_o != '1));

endmodule

// File: rtl/vfd_scan_timer.sv
module vfd_scan_timer
  import vfd_scan_pkg::*;
#(
  parameter int unsigned OSC_DIV   = 4,
  parameter int unsigned SLOT_BITS = 1024,
  parameter int unsigned DIM_W     = 10,
  parameter int unsigned DIM_CAP   = 1016,
  parameter int unsigned SEG_LEAD  = 3,
  parameter int unsigned SEG_TRAIL = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             osc_en_i,
  input  logic             duplex_i,
  input  logic [DIM_W-1:0] dim_i,
  output logic [2:0]       grid_no_o,
  output logic [1:0]       grid_idx_o,
  output logic             seg_en_o,
  output logic             dim_out_o,
  output logic [1:0]       sync_o
);
  localparam int unsigned BW = $clog2(SLOT_BITS);

  logic             bit_tick;
  logic [BW-1:0]    bit_pos;
  grid_code_e       grid;
  logic [DIM_W-1:0] duty;

  vfd_prescale #(.OSC_DIV(OSC_DIV)) u_prescale (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .osc_en_i   (osc_en_i),
    .bit_tick_o (bit_tick)
  );

  vfd_slot_seq #(
    .SLOT_BITS (SLOT_BITS),
    .DIM_W     (DIM_W),
    .DIM_CAP   (DIM_CAP)
  ) u_slot_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_tick_i (bit_tick),
    .duplex_i   (duplex_i),
    .dim_i      (dim_i),
    .bit_pos_o  (bit_pos),
    .grid_o     (grid),
    .duty_o     (duty)
  );

  vfd_pulse_gen #(
    .BW        (BW),
    .DIM_W     (DIM_W),
    .SEG_LEAD  (SEG_LEAD),
    .SEG_TRAIL (SEG_TRAIL)
  ) u_pulse_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_pos_i (bit_pos),
    .grid_i    (grid),
    .duty_i    (duty),
    .grid_no_o (grid_no_o),
    .seg_en_o  (seg_en_o),
    .dim_out_o (dim_out_o)
  );

  assign grid_idx_o = grid;
  assign sync_o     = grid;

  // R8
  sync_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o == grid_idx_o);

  // R3
  duplex_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duplex_i && $stable(duplex_i) && $past(grid_idx_o) != 2'b10) |-> grid_idx_o != 2'b10);

endmodule

// File: tb/vfd_scan_timer_bench.sv
module vfd_scan_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int OSC_DIV    = 4;
  localparam int SLOT_BITS  = 1024;
  localparam int DIM_CAP    = 1016;
  localparam int SEG_LEAD   = 3;
  localparam int SEG_TRAIL  = 5;
  localparam int SLOT_CLK   = OSC_DIV * SLOT_BITS;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       osc_en_i = 1'b0;
  logic       duplex_i = 1'b0;
  logic [9:0] dim_i = '0;
  logic [2:0] grid_no_o;
  logic [1:0] grid_idx_o;
  logic       seg_en_o;
  logic       dim_out_o;
  logic [1:0] sync_o;

  int vectors = 0;
  int miscompares = 0;
  int n_en = 0;
  int eff = 0;
  int ngrids = 3;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  vfd_scan_timer #(
    .OSC_DIV(OSC_DIV), .SLOT_BITS(SLOT_BITS), .DIM_W(10),
    .DIM_CAP(DIM_CAP), .SEG_LEAD(SEG_LEAD), .SEG_TRAIL(SEG_TRAIL)
  ) u_vfd_scan_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .osc_en_i(osc_en_i), .duplex_i(duplex_i),
    .dim_i(dim_i), .grid_no_o(grid_no_o), .grid_idx_o(grid_idx_o),
    .seg_en_o(seg_en_o), .dim_out_o(dim_out_o), .sync_o(sync_o)
  );

  function automatic int sat_dim(int d);
    return (d > DIM_CAP) ? DIM_CAP : d;
  endfunction

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s act=%0d exp=%0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_model();
    int bt, slot, b, g, exp_grid;
    bit on;
    bt   = n_en / OSC_DIV;
    slot = bt / SLOT_BITS;
    b    = bt % SLOT_BITS;
    g    = slot % ngrids;
    on   = b < eff;
    exp_grid = on ? (7 & ~(1 << g)) : 7;
    check("R4 R5 R9 grid lines", int'(grid_no_o), exp_grid);
    check("R3 grid index", int'(grid_idx_o), g);
    check("R8 sync code", int'(sync_o), g);
    check("R6 segment enable", int'(seg_en_o), int'(b >= SEG_LEAD && b + SEG_TRAIL < eff));
    check("R7 dim out", int'(dim_out_o), int'(on));
  endtask

  task automatic check_reset(string tag);
    check(tag, int'(grid_no_o), 7);
    check(tag, int'(seg_en_o), 0);
    check(tag, int'(dim_out_o), 0);
    check(tag, int'(sync_o), 0);
    check(tag, int'(grid_idx_o), 0);
  endtask

  task automatic run_phase(bit dup, int cycles);
    int dir [10] = '{1, 1016, 9, 1023, 0, 8, 1017, 500, 1015, 700};
    int di = 0;
    @(negedge clk_i);
    rst_ni   = 1'b0;
    osc_en_i = 1'b0;
    duplex_i = dup;
    dim_i    = 10'd1023;
    ngrids   = dup ? 2 : 3;
    repeat (3) @(negedge clk_i);
    check_reset("R1 reset state");
    rst_ni = 1'b1;
    n_en = 0;
    eff  = 0;
    // enable held low: nothing moves
    repeat (20) @(negedge clk_i);
    check_reset("R2 hold while osc_en low");
    // dim_i was 1023 during reset but the first slot stays dark
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk_i);
      check_model();
      if (i % 3000 == 1500) begin
        if (di < 10) dim_i = 10'(dir[di]);
        else         dim_i = 10'($urandom_range(0, 1023));
        di++;
      end
      osc_en_i = (($urandom % 8) != 0);
      if (osc_en_i) begin
        n_en++;
        if (n_en % SLOT_CLK == 0) eff = sat_dim(int'(dim_i));
      end
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    run_phase(1'b0, 50000);
    run_phase(1'b1, 36000);
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk_i);
      wd++;
      if (wd > 190000 && !done) begin
        done = 1;
        vectors++;
        miscompares++;
        $display("FAIL watchdog act=%0d exp=%0d", wd, 190000);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
      end
    end
  end

endmodule